// File: doc/BRIEF.md
# Voice PCM Serial Port

This block is a full-duplex serial port for a stream of 13-bit two's-complement voice samples. It shifts a transmit sample out, most significant bit first, on a data line that is driven only while sample bits are on it. At the same time it assembles receive samples from a data input. Each direction has its own frame sync and bit clock. Frames can be marked either by a one-bit-wide sync pulse that comes one bit period ahead of the word (short) or by a sync level that spans the word (long).

The bit clocks and frame syncs are slow external signals. A fast system clock samples them through a synchronizer, and all framing runs on the edges seen there. A two-bit mode input selects the word layout. In the split mode, each direction uses its own bit clock and words are 13 bits. In the sign-extended mode, 16-bit words carry the sign bit four times. In the gain mode, a 16-bit receive word ends in a 3-bit attenuation code. The two shared modes clock both directions from the transmit bit clock. A finished receive word is presented with a one-cycle strobe.

Top module: `pcm_voice_port`

## Requirements
- R1: While `rst` is high and right after it, `tx_oe`, `tx_data`, `rx_sample`, `rx_gain` and `rx_valid` are all 0.
- R2: With `long_fs` = 0, a frame sync seen high at a bit clock falling edge starts a word. Its MSB is driven from the next bit clock rising edge, and `tx_oe` rises at that edge.
- R3: `tx_data` changes only after a transmit bit clock rising edge or a transmit frame sync rising edge. Each rising edge of the word moves to the next bit, MSB first.
- R4: With `long_fs` = 1, the MSB appears at whichever comes later, the frame sync rising edge or the bit clock rising edge.
- R5: `tx_oe` drops after the 13th falling bit clock edge of the word, or after the 16th in the sign-extended mode. With `long_fs` = 1 it stays high until the frame sync has also fallen.
- R6: With `mode_sel` = 1 (sign-extended), both directions move 16 bits. Transmit sends three extra copies of the sign bit ahead of the 13 sample bits. Receive keeps the last 13 bits. Both directions use `tx_bclk`, and `rx_bclk` is ignored.
- R7: With `mode_sel` = 2 (gain), transmit sends 13 bits and receive takes 16 bits: 13 sample bits and then a 3-bit code on `rx_gain`. The code means attenuation in 3 dB steps, 000 = 0 dB up to 111 = 21 dB. `rx_gain` changes only on words received in this mode.
- R8: `rx_sample` (and `rx_gain`) update together only after the last bit of a receive word has been captured. `rx_valid` is high for exactly one cycle in that same cycle. At all other times the outputs hold.
- R9: Receive bits are sampled on bit clock falling edges. With `mode_sel` = 0 or 3 (split), receive uses `rx_bclk` and `rx_fs`, independent of the transmit frame timing.
- R10: A frame sync that arrives while a word is being shifted is ignored in both directions. Once the word ends, no new word starts until a later frame sync.
- R11: Samples are two's complement. Positive full scale 0 1111 1111 1111 and negative full scale 1 0000 0000 0000 pass through unchanged in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial signals |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 0/3 split, 1 sign-extended, 2 gain |
| long_fs | input | 1 | 1 = long frame sync timing, 0 = short |
| tx_bclk | input | 1 | Transmit bit clock (also receive clock in shared modes) |
| tx_fs | input | 1 | Transmit frame sync |
| tx_sample | input | 13 | Sample captured at the start of each transmit word |
| tx_data | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable for `tx_data` (high = driven) |
| rx_bclk | input | 1 | Receive bit clock in split mode |
| rx_fs | input | 1 | Receive frame sync |
| rx_data | input | 1 | Serial receive data |
| rx_sample | output | 13 | Last received sample |
| rx_gain | output | 3 | Last received attenuation code |
| rx_valid | output | 1 | One-cycle strobe when a receive word is committed |

## Verification
The bench walks every mode with both sync styles and with full-scale and mixed bit patterns. It checks each transmit bit against the value expected for that bit period. A design that started one period early under short sync, or that began a long-sync word at the sync edge while the bit clock was low, would show every bit shifted by one. The bench holds a long sync past the word end to catch an enable that drops too soon. It pulses a sync in the middle of a word to catch a restart that would garble the word or add a second strobe. It also runs receive-only and transmit-only frames, and frames in the shared modes with `rx_bclk` held still. A design that mixed up the clock selection, leaked the gain code from other modes, or drove the line without a transmit sync would fail these checks.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  typedef enum logic [1:0] {
    PM_SPLIT   = 2'd0,
    PM_SIGNEXT = 2'd1,
    PM_GAIN    = 2'd2
  } pcm_mode_e;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_ARMED,
    FS_SHIFT,
    FS_HOLD
  } frm_state_e;

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prv
);

  logic [STAGES-1:0][W-1:0] chain;
  logic [W-1:0]             last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= chain[STAGES-1];
  end

  assign lvl = chain[STAGES-1];
  assign prv = last_q;

endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
  import pcm_port_pkg::*;
#(
  parameter int SAMPLE_W = 13,
  parameter int WORD_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                long_fs,
  input  logic                sign_ext,
  input  logic                bclk_lvl,
  input  logic                bclk_rise,
  input  logic                bclk_fall,
  input  logic                fs_lvl,
  input  logic                fs_rise,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic                tx_data,
  output logic                tx_oe
);

  localparam int PAD_W = WORD_W - SAMPLE_W;
  localparam int CNT_W = $clog2(WORD_W + 1);

  frm_state_e         st;
  logic [WORD_W-1:0]  sreg;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   len;
  logic [WORD_W-1:0]  load_word;
  logic [CNT_W-1:0]   load_len;
  logic [CNT_W-1:0]   cnt_inc;

  always_comb begin
    if (sign_ext) begin
      load_word = {{PAD_W{sample_in[SAMPLE_W-1]}}, sample_in};
      load_len  = CNT_W'(WORD_W);
    end else begin
      load_word = {sample_in, {PAD_W{1'b0}}};
      load_len  = CNT_W'(SAMPLE_W);
    end
    cnt_inc = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= FS_IDLE;
      sreg  <= '0;
      cnt   <= '0;
      len   <= '0;
      tx_oe <= 1'b0;
    end else begin
      case (st)
        FS_IDLE: begin
          if (long_fs && fs_rise) begin
            if (bclk_lvl) begin
              sreg  <= load_word;
              len   <= load_len;
              cnt   <= '0;
              tx_oe <= 1'b1;
              st    <= FS_SHIFT;
            end else begin
              st <= FS_ARMED;
            end
          end else if (!long_fs && bclk_fall && fs_lvl) begin
            st <= FS_ARMED;
          end
        end
        FS_ARMED: begin
          if (bclk_rise) begin
            sreg  <= load_word;
            len   <= load_len;
            cnt   <= '0;
            tx_oe <= 1'b1;
            st    <= FS_SHIFT;
          end
        end
        FS_SHIFT: begin
          if (bclk_rise) sreg <= {sreg[WORD_W-2:0], 1'b0};
          if (bclk_fall) begin
            cnt <= cnt_inc;
            if (cnt_inc == len) begin
              if (long_fs && fs_lvl) begin
                st <= FS_HOLD;
              end else begin
                tx_oe <= 1'b0;
                st    <= FS_IDLE;
              end
            end
          end
        end
        default: begin
          if (!fs_lvl) begin
            tx_oe <= 1'b0;
            st    <= FS_IDLE;
          end
        end
      endcase
    end
  end

  assign tx_data = sreg[WORD_W-1];

  // R3
  tx_data_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!bclk_rise && !fs_rise) |=> $stable(tx_data));

  // R5
  tx_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st == FS_SHIFT) |-> (cnt < len));

  // R10
  tx_fs_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (st == FS_SHIFT && fs_rise && !bclk_fall) |=> (st == FS_SHIFT && tx_oe));

endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift
  import pcm_port_pkg::*;
#(
  parameter int SAMPLE_W = 13,
  parameter int WORD_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       long_fs,
  input  pcm_mode_e                  mode,
  input  logic                       bclk_fall,
  input  logic                       fs_lvl,
  input  logic                       fs_rise,
  input  logic                       din,
  output logic [SAMPLE_W-1:0]        sample_out,
  output logic [WORD_W-SAMPLE_W-1:0] gain_out,
  output logic                       valid
);

  localparam int EXT_W = WORD_W - SAMPLE_W;
  localparam int CNT_W = $clog2(WORD_W + 1);

  frm_state_e         st;
  pcm_mode_e          mode_q;
  logic [WORD_W-1:0]  sreg;
  logic [WORD_W-1:0]  nxt;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   len;
  logic [CNT_W-1:0]   cnt_inc;
  logic [CNT_W-1:0]   start_len;

  always_comb begin
    nxt       = {sreg[WORD_W-2:0], din};
    cnt_inc   = cnt + 1'b1;
    start_len = (mode == PM_SPLIT) ? CNT_W'(SAMPLE_W) : CNT_W'(WORD_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= FS_IDLE;
      mode_q     <= PM_SPLIT;
      sreg       <= '0;
      cnt        <= '0;
      len        <= '0;
      sample_out <= '0;
      gain_out   <= '0;
      valid      <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        FS_IDLE: begin
          if ((long_fs && fs_rise) || (!long_fs && bclk_fall && fs_lvl)) begin
            mode_q <= mode;
            len    <= start_len;
            cnt    <= '0;
            st     <= long_fs ? FS_SHIFT : FS_ARMED;
          end
        end
        FS_ARMED, FS_SHIFT: begin
          if (bclk_fall) begin
            sreg <= nxt;
            cnt  <= cnt_inc;
            st   <= FS_SHIFT;
            if (cnt_inc == len) begin
              valid <= 1'b1;
              st    <= FS_IDLE;
              if (mode_q == PM_GAIN) begin
                sample_out <= nxt[WORD_W-1 -: SAMPLE_W];
                gain_out   <= nxt[EXT_W-1:0];
              end else begin
                sample_out <= nxt[SAMPLE_W-1:0];
              end
            end
          end
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  // R8
  rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (valid || $stable(sample_out)));

  // R7
  rx_gain_mode_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(gain_out) || $past(mode_q) == PM_GAIN));

  // R9
  rx_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (st == FS_SHIFT) |-> (cnt < len));

endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_port_pkg::*;
#(
  parameter int SAMPLE_W    = 13,
  parameter int EXT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode_sel,
  input  logic                long_fs,
  input  logic                tx_bclk,
  input  logic                tx_fs,
  input  logic [SAMPLE_W-1:0] tx_sample,
  output logic                tx_data,
  output logic                tx_oe,
  input  logic                rx_bclk,
  input  logic                rx_fs,
  input  logic                rx_data,
  output logic [SAMPLE_W-1:0] rx_sample,
  output logic [EXT_W-1:0]    rx_gain,
  output logic                rx_valid
);

  localparam int WORD_W = SAMPLE_W + EXT_W;

  // sync bit order: 0 tx_bclk, 1 tx_fs, 2 rx_bclk, 3 rx_fs
  logic [3:0]             s_lvl;
  logic [3:0]             s_prv;
  logic [SYNC_STAGES-1:0] din_sync;
  pcm_mode_e              mode;
  logic                   shared_clk;
  logic                   tx_rise, tx_fall, tx_fs_rise;
  logic                   rx_fall, rx_fs_rise;

  pcm_edge_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({rx_fs, rx_bclk, tx_fs, tx_bclk}),
    .lvl (s_lvl),
    .prv (s_prv)
  );

  always_ff @(posedge clk) begin
    if (rst) din_sync <= '0;
    else     din_sync <= {din_sync[SYNC_STAGES-2:0], rx_data};
  end

  always_comb begin
    mode       = (mode_sel == 2'd3) ? PM_SPLIT : pcm_mode_e'(mode_sel);
    shared_clk = (mode != PM_SPLIT);
    tx_rise    = s_lvl[0] & ~s_prv[0];
    tx_fall    = ~s_lvl[0] & s_prv[0];
    tx_fs_rise = s_lvl[1] & ~s_prv[1];
    rx_fall    = shared_clk ? tx_fall : (~s_lvl[2] & s_prv[2]);
    rx_fs_rise = s_lvl[3] & ~s_prv[3];
  end

  pcm_tx_shift #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .long_fs   (long_fs),
    .sign_ext  (mode == PM_SIGNEXT),
    .bclk_lvl  (s_lvl[0]),
    .bclk_rise (tx_rise),
    .bclk_fall (tx_fall),
    .fs_lvl    (s_lvl[1]),
    .fs_rise   (tx_fs_rise),
    .sample_in (tx_sample),
    .tx_data   (tx_data),
    .tx_oe     (tx_oe)
  );

  pcm_rx_shift #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .long_fs    (long_fs),
    .mode       (mode),
    .bclk_fall  (rx_fall),
    .fs_lvl     (s_lvl[3]),
    .fs_rise    (rx_fs_rise),
    .din        (din_sync[SYNC_STAGES-1]),
    .sample_out (rx_sample),
    .gain_out   (rx_gain),
    .valid      (rx_valid)
  );

endmodule

// File: tb/pcm_voice_port_bench.sv
module pcm_voice_port_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_sel = 2'd0;
  logic        long_fs = 1'b0;
  logic        tx_bclk = 1'b0, tx_fs = 1'b0;
  logic [12:0] tx_sample = '0;
  logic        tx_data, tx_oe;
  logic        rx_bclk = 1'b0, rx_fs = 1'b0, rx_data = 1'b0;
  logic [12:0] rx_sample;
  logic [2:0]  rx_gain;
  logic        rx_valid;

  int checks = 0;
  int errors = 0;
  int vtotal = 0;
  bit done = 0;
  logic [12:0] exp_sample = '0;
  logic [2:0]  exp_gain = '0;

  always #10 clk = ~clk;

  pcm_voice_port u_pcm_voice_port (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .long_fs(long_fs),
    .tx_bclk(tx_bclk), .tx_fs(tx_fs), .tx_sample(tx_sample),
    .tx_data(tx_data), .tx_oe(tx_oe),
    .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_data(rx_data),
    .rx_sample(rx_sample), .rx_gain(rx_gain), .rx_valid(rx_valid)
  );

  always @(posedge clk) if (rx_valid) vtotal++;

  // vector: {mode[1:0], long, tx word[12:0], rx word[15:0]}
  localparam logic [31:0] VEC [8] = '{
    {2'd0, 1'b0, 13'h0FFF, 16'h8000},
    {2'd0, 1'b1, 13'h1000, 16'h7FF8},
    {2'd1, 1'b0, 13'h1234, 16'hF876},
    {2'd1, 1'b1, 13'h0A5A, 16'h0321},
    {2'd2, 1'b0, 13'h1FFF, 16'hABCD},
    {2'd2, 1'b1, 13'h0001, 16'h1237},
    {2'd0, 1'b0, 13'h0000, 16'h0001},
    {2'd3, 1'b0, 13'h0555, 16'h5558}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [1:0] md, input logic lng, input logic early,
                           input logic [12:0] txw, input logic [15:0] rxw,
                           input bit tx_en, input bit rx_en, input int hold,
                           input bit retrig, input string tag);
    bit split = (md == 2'd0) || (md == 2'd3);
    int ntx = (md == 2'd1) ? 16 : 13;
    int nrx = split ? 13 : 16;
    logic [15:0] exp16 = (md == 2'd1) ? {{3{txw[12]}}, txw} : {txw, 3'b000};
    int last;
    int v0;
    bit fsv;
    last = (ntx > nrx) ? ntx : nrx;
    if (hold > last) last = hold;
    last = last + 2;
    @(negedge clk);
    mode_sel  = md;
    long_fs   = lng;
    tx_sample = txw;
    v0 = vtotal;
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      tx_bclk = 1'b1;
      rx_bclk = split ? 1'b1 : 1'b0;
      if (!lng) fsv = (k == 0) || (retrig && k == 5);
      else if (k == 1 && !early) fsv = 1'b1;
      else if (k == hold + 1) fsv = 1'b0;
      if (!lng || !(early && k == 0)) begin
        if (!lng || k == 1 || k == hold + 1) begin
          tx_fs = tx_en ? fsv : 1'b0;
          rx_fs = rx_en ? fsv : 1'b0;
        end
      end
      rx_data = (rx_en && k >= 1 && k <= nrx) ? rxw[16-k] : 1'b0;
      repeat (7) @(negedge clk);
      if (tx_en && k >= 1 && k <= ntx) begin
        // R2 R3 R4 R6 R11: bit order and start period
        chk(tx_data == exp16[16-k], {tag, " R3 tx bit"}, int'(tx_data), int'(exp16[16-k]));
        chk(tx_oe == 1'b1, {tag, " R2 oe during word"}, int'(tx_oe), 1);
      end else begin
        // R5 R10: enable window
        chk(tx_oe == (tx_en && lng && k >= 1 && k <= hold),
            {tag, " R5 oe outside word"}, int'(tx_oe), int'(tx_en && lng && k >= 1 && k <= hold));
      end
      @(negedge clk);
      tx_bclk = 1'b0;
      rx_bclk = 1'b0;
      if (lng && early && k == 0) begin
        repeat (4) @(negedge clk);
        fsv = 1'b1;
        tx_fs = tx_en;
        rx_fs = rx_en;
        repeat (3) @(negedge clk);
      end else begin
        repeat (7) @(negedge clk);
      end
    end
    tx_fs = 1'b0;
    rx_fs = 1'b0;
    repeat (8) @(negedge clk);
    if (rx_en) begin
      exp_sample = (md == 2'd1) ? rxw[12:0] : rxw[15:3];
      if (md == 2'd2) exp_gain = rxw[2:0];
    end
    // R8 R10: exactly one strobe per receive word
    chk((vtotal - v0) == (rx_en ? 1 : 0), {tag, " R8 strobe count"}, vtotal - v0, rx_en ? 1 : 0);
    // R9 R6 R11: received sample
    chk(rx_sample == exp_sample, {tag, " R9 rx sample"}, int'(rx_sample), int'(exp_sample));
    // R7: gain code
    chk(rx_gain == exp_gain, {tag, " R7 rx gain"}, int'(rx_gain), int'(exp_gain));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(tx_oe == 1'b0 && tx_data == 1'b0, "R1 tx reset", {30'd0, tx_oe, tx_data}, 0);
    chk(rx_sample == '0 && rx_gain == '0 && rx_valid == 1'b0, "R1 rx reset",
        int'({rx_sample, rx_gain, rx_valid}), 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(tx_oe == 1'b0, "R1 after release", int'(tx_oe), 0);

    foreach (VEC[i]) begin
      run_frame(VEC[i][31:30], VEC[i][29], 1'b0, VEC[i][28:16], VEC[i][15:0],
                1'b1, 1'b1, VEC[i][29] ? 4 : 0, 1'b0, "table");
    end

    // R4: long sync raised while the bit clock is low
    run_frame(2'd0, 1'b1, 1'b1, 13'h1A5A, 16'hC3A8, 1'b1, 1'b1, 4, 1'b0, "R4 late clock");
    // R5: long sync held past the end of the word
    run_frame(2'd2, 1'b1, 1'b0, 13'h0F0F, 16'h5552, 1'b1, 1'b1, 15, 1'b0, "R5 hold");
    run_frame(2'd1, 1'b1, 1'b0, 13'h1F00, 16'h00F1, 1'b1, 1'b1, 18, 1'b0, "R5 hold16");
    // R10: sync pulse in the middle of a word
    run_frame(2'd0, 1'b0, 1'b0, 13'h1357, 16'h2468, 1'b1, 1'b1, 0, 1'b1, "R10 retrig");
    run_frame(2'd2, 1'b0, 1'b0, 13'h0ACE, 16'hBEE3, 1'b1, 1'b1, 0, 1'b1, "R10 retrig gain");
    // R9: receive frame alone, transmit stays released
    run_frame(2'd0, 1'b0, 1'b0, 13'h1111, 16'h9990, 1'b0, 1'b1, 0, 1'b0, "R9 rx only");
    // R6: transmit only in shared mode, no receive strobe
    run_frame(2'd1, 1'b0, 1'b0, 13'h0800, 16'hFFFF, 1'b1, 1'b0, 0, 1'b0, "R6 tx only");

    // R1: reset clears held receive results
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_sample == '0 && rx_gain == '0, "R1 re-reset", int'({rx_sample, rx_gain}), 0);
    rst = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule